// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block forms the effective address of a load or store and the updated base value that goes back to the register file. It works on a 32-bit address path. The offset comes from a register operand or from a short unsigned immediate. Before use, the offset is scaled to bytes by the access size. The scaled offset is then added to or subtracted from the base.

Each addressable base register is linear or circular, as set by a two-bit field in a shared mode word. A circular register uses one of two block-size fields in the same word. In circular mode, the arithmetic may change only the low address bits inside a power-of-two byte block. All bits above the block keep the base value's bits, so the pointer wraps inside its buffer however large the offset is.

A request is taken on a cycle with `reqValid` high. Its results appear, registered, on the next cycle.

Top module: `cbag_top`

## Requirements
- R1: The offset is scaled to bytes by a left shift of `accSize`: 0 byte, 1 halfword, 2 word, 3 doubleword.
- R2: With `subtract` high the scaled offset is taken away from the base; with it low the scaled offset is added. Arithmetic wraps modulo 2^32.
- R3: Register `regIdx` has its mode field at `modeReg[2*regIdx+1 : 2*regIdx]`. Mode 01 selects circular addressing with block field 0 at `modeReg[20:16]`. For a field value F, result bits F..0 take the arithmetic value and bits 31..F+1 keep the base bits. The block is therefore 2^(F+1) bytes.
- R4: Mode 10 selects circular addressing using block field 1 at `modeReg[25:21]`, with the same rule as R3.
- R5: Modes 00 and 11 both give plain linear addressing.
- R6: `form` 01 (pre-modify) drives `memAddr` with the modified value, drives `newBase` with the modified value, and raises `wbEn`.
- R7: `form` 10 (post-modify) drives `memAddr` with the unmodified base, drives `newBase` with the modified value, and raises `wbEn`.
- R8: `form` 00 or 11 (offset only) drives `memAddr` with the modified value, following the same linear or circular rule, and keeps `wbEn` low.
- R9: A block field of 31 updates all 32 bits, so the result equals linear mode.
- R10: With `useImm` high the offset is `offImm`, zero-extended. With it low the offset is `offReg`.
- R11: Results appear one cycle after `reqValid`. `outValid` follows `reqValid` with one cycle of delay. Reset clears `outValid`, `wbEn`, `memAddr` and `newBase`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe |
| baseVal | input | 32 | Current base register value |
| regIdx | input | 3 | Index of the base register, selects its mode field |
| offReg | input | 32 | Register offset operand |
| offImm | input | 5 | Immediate offset operand, unsigned |
| useImm | input | 1 | 1 selects the immediate offset |
| accSize | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 doubleword |
| subtract | input | 1 | 1 subtracts the offset, 0 adds it |
| form | input | 2 | 00 offset only, 01 pre-modify, 10 post-modify, 11 offset only |
| modeReg | input | 32 | Per-register modes and both block-size fields |
| outValid | output | 1 | Results valid |
| memAddr | output | 32 | Memory address |
| newBase | output | 32 | Updated base value |
| wbEn | output | 1 | Base writeback enable |

## Verification
The hardest case to reach is a carry or borrow that would cross the block boundary. Such a case shows whether the upper bits really stay frozen, and only specific pairs of base, offset and block field produce it. The stimulus picks those pairs on purpose:
- a word offset that steps 4 bytes past a 32-byte block;
- a byte subtraction that borrows out of a 2-byte block;
- a halfword step that crosses an 8-byte block through field 1.

A 32-bit overflow under a field of 31 checks the opposite extreme, where nothing may be frozen.

// File: rtl/cbag_pkg.sv
package cbag_pkg;
  localparam int ADDR_W = 32;
  localparam int FIELD_W = 5;

  typedef enum logic [1:0] {
    FORM_PLAIN = 2'b00,
    FORM_PRE   = 2'b01,
    FORM_POST  = 2'b10,
    FORM_PLN2  = 2'b11
  } form_e;

  typedef enum logic [1:0] {
    MODE_LIN  = 2'b00,
    MODE_CB0  = 2'b01,
    MODE_CB1  = 2'b10,
    MODE_RSV  = 2'b11
  } mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic               circEn;
    logic [FIELD_W-1:0] blkN;
    logic               addrPre;
    logic               wbReq;
  } strobe_t;
endpackage

// File: rtl/cbag_ctrl.sv
module cbag_ctrl
  import cbag_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int IDX_W = $clog2(NUM_REGS),
  parameter int BLK0_LSB = 16,
  parameter int BLK1_LSB = 21
) (
  input  logic [IDX_W-1:0]  regIdx,
  input  logic [ADDR_W-1:0] modeReg,
  input  logic [1:0]        form,
  output strobe_t           strobes
);
  logic [1:0] regMode [NUM_REGS];
  logic [1:0] selMode;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_REGS; gi++) begin : g_mode
      assign regMode[gi] = modeReg[2*gi +: 2];
    end
  endgenerate

  assign selMode = regMode[regIdx];

  always_comb begin
    strobes = '0;
    unique case (mode_e'(selMode))
      MODE_CB0: begin
        strobes.circEn = 1'b1;
        strobes.blkN   = modeReg[BLK0_LSB +: FIELD_W];
      end
      MODE_CB1: begin
        strobes.circEn = 1'b1;
        strobes.blkN   = modeReg[BLK1_LSB +: FIELD_W];
      end
      default: begin
        strobes.circEn = 1'b0;
        strobes.blkN   = '0;
      end
    endcase
    unique case (form_e'(form))
      FORM_PRE:  begin strobes.addrPre = 1'b1; strobes.wbReq = 1'b1; end
      FORM_POST: begin strobes.addrPre = 1'b0; strobes.wbReq = 1'b1; end
      default:   begin strobes.addrPre = 1'b1; strobes.wbReq = 1'b0; end
    endcase
  end
endmodule

// File: rtl/cbag_dp.sv
module cbag_dp
  import cbag_pkg::*;
#(
  parameter int IMM_W = 5
) (
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [ADDR_W-1:0] offReg,
  input  logic [IMM_W-1:0]  offImm,
  input  logic              useImm,
  input  logic [1:0]        accSize,
  input  logic              subtract,
  input  strobe_t           strobes,
  output logic [ADDR_W-1:0] addrNext,
  output logic [ADDR_W-1:0] baseNext
);
  localparam int SH_W = $clog2(ADDR_W) + 1;
  localparam logic [SH_W-1:0] TOP_BIT = SH_W'(ADDR_W - 1);

  logic [ADDR_W-1:0] offRaw;
  logic [ADDR_W-1:0] offScaled;
  logic [ADDR_W-1:0] sumVal;
  logic [ADDR_W-1:0] lowMask;
  logic [SH_W-1:0]   shAmt;
  logic [ADDR_W-1:0] modVal;

  assign offRaw    = useImm ? ADDR_W'(offImm) : offReg;
  assign offScaled = offRaw << accSize;
  assign sumVal    = subtract ? (baseVal - offScaled) : (baseVal + offScaled);

  // bits blkN..0 are free; blkN = 31 frees the whole word
  assign shAmt   = TOP_BIT - SH_W'(strobes.blkN);
  assign lowMask = strobes.circEn ? ({ADDR_W{1'b1}} >> shAmt) : {ADDR_W{1'b1}};
  assign modVal  = (sumVal & lowMask) | (baseVal & ~lowMask);

  assign addrNext = strobes.addrPre ? modVal : baseVal;
  assign baseNext = modVal;
endmodule

// File: rtl/cbag_top.sv
module cbag_top
  import cbag_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int IDX_W = $clog2(NUM_REGS),
  parameter int IMM_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [31:0]       baseVal,
  input  logic [IDX_W-1:0]  regIdx,
  input  logic [31:0]       offReg,
  input  logic [IMM_W-1:0]  offImm,
  input  logic              useImm,
  input  logic [1:0]        accSize,
  input  logic              subtract,
  input  logic [1:0]        form,
  input  logic [31:0]       modeReg,
  output logic              outValid,
  output logic [31:0]       memAddr,
  output logic [31:0]       newBase,
  output logic              wbEn
);
  strobe_t           strobes;
  logic [ADDR_W-1:0] addrNext;
  logic [ADDR_W-1:0] baseNext;

  cbag_ctrl #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_ctrl (
    .regIdx (regIdx),
    .modeReg(modeReg),
    .form   (form),
    .strobes(strobes)
  );

  cbag_dp #(.IMM_W(IMM_W)) u_dp (
    .baseVal (baseVal),
    .offReg  (offReg),
    .offImm  (offImm),
    .useImm  (useImm),
    .accSize (accSize),
    .subtract(subtract),
    .strobes (strobes),
    .addrNext(addrNext),
    .baseNext(baseNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      wbEn     <= 1'b0;
      memAddr  <= '0;
      newBase  <= '0;
    end else begin
      outValid <= reqValid;
      wbEn     <= reqValid & strobes.wbReq;
      if (reqValid) begin
        memAddr <= addrNext;
        newBase <= baseNext;
      end
    end
  end
endmodule

// File: rtl/cbag_chk.sv
module cbag_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic [31:0]      baseVal,
  input logic [IDX_W-1:0] regIdx,
  input logic [1:0]       form,
  input logic [31:0]      modeReg,
  input logic             outValid,
  input logic [31:0]      memAddr,
  input logic [31:0]      newBase,
  input logic             wbEn
);
  logic [1:0]  curMode;
  logic [4:0]  curField;
  logic [31:0] keepMask;

  assign curMode  = modeReg[2*regIdx +: 2];
  assign curField = (curMode == 2'b10) ? modeReg[25:21] : modeReg[20:16];
  assign keepMask = ~(32'hFFFF_FFFF >> (5'd31 - curField));

  // R11
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> outValid);
  // R11
  idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!outValid && !wbEn));
  // R6
  pre_form_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && form == 2'b01) |=> (wbEn && memAddr == newBase));
  // R7
  post_form_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && form == 2'b10) |=> (wbEn && memAddr == $past(baseVal)));
  // R8
  plain_form_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && form[1] == form[0]) |=> (!wbEn && memAddr == newBase));
  // R3
  circ_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (curMode == 2'b01 || curMode == 2'b10))
      |=> (((newBase ^ $past(baseVal)) & $past(keepMask)) == 32'h0));
endmodule

bind cbag_top cbag_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .baseVal(baseVal),
  .regIdx(regIdx), .form(form), .modeReg(modeReg), .outValid(outValid),
  .memAddr(memAddr), .newBase(newBase), .wbEn(wbEn)
);

// File: tb/tb_cbag_top.sv
module tb_cbag_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] baseVal = '0;
  logic [2:0]  regIdx = '0;
  logic [31:0] offReg = '0;
  logic [4:0]  offImm = '0;
  logic        useImm = 1'b0;
  logic [1:0]  accSize = '0;
  logic        subtract = 1'b0;
  logic [1:0]  form = '0;
  logic [31:0] modeReg = '0;
  logic        outValid;
  logic [31:0] memAddr;
  logic [31:0] newBase;
  logic        wbEn;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cbag_top dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .baseVal(baseVal),
    .regIdx(regIdx), .offReg(offReg), .offImm(offImm), .useImm(useImm),
    .accSize(accSize), .subtract(subtract), .form(form), .modeReg(modeReg),
    .outValid(outValid), .memAddr(memAddr), .newBase(newBase), .wbEn(wbEn)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one request at a falling edge, sample results one falling edge later
  task automatic issue(input logic [31:0] base, input logic [2:0] idx,
                       input logic [31:0] oReg, input logic [4:0] oImm, input logic imm,
                       input logic [1:0] sz, input logic sub, input logic [1:0] frm,
                       input logic [31:0] mode);
    @(negedge clk);
    reqValid = 1'b1; baseVal = base; regIdx = idx; offReg = oReg; offImm = oImm;
    useImm = imm; accSize = sz; subtract = sub; form = frm; modeReg = mode;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic t_reset;
    check("R11 reset outValid", {31'b0, outValid}, 32'h0);
    check("R11 reset wbEn", {31'b0, wbEn}, 32'h0);
    check("R11 reset memAddr", memAddr, 32'h0);
    check("R11 reset newBase", newBase, 32'h0);
  endtask

  task automatic t_wrapExample;
    // word pre-increment by 9 in a 32-byte block
    issue(32'h100, 3'd0, 32'd9, 5'd0, 1'b0, 2'd2, 1'b0, 2'b01, 32'h0004_0001);
    check("R11 outValid", {31'b0, outValid}, 32'h1);
    check("R3 addr", memAddr, 32'h104);
    check("R6 newBase", newBase, 32'h104);
    check("R6 wbEn", {31'b0, wbEn}, 32'h1);
  endtask

  task automatic t_scale;
    logic [31:0] expA [4] = '{32'h1003, 32'h1006, 32'h100C, 32'h1018};
    for (int s = 0; s < 4; s++) begin
      issue(32'h1000, 3'd0, 32'd3, 5'd0, 1'b0, 2'(s), 1'b0, 2'b00, 32'h0);
      check("R1 scaled addr", memAddr, expA[s]);
      check("R8 no wb", {31'b0, wbEn}, 32'h0);
    end
    issue(32'h1000, 3'd0, 32'd3, 5'd0, 1'b0, 2'd1, 1'b0, 2'b11, 32'h0);
    check("R8 form11 addr", memAddr, 32'h1006);
    check("R8 form11 no wb", {31'b0, wbEn}, 32'h0);
  endtask

  task automatic t_subtract;
    issue(32'h2000, 3'd0, 32'd4, 5'd0, 1'b0, 2'd2, 1'b1, 2'b01, 32'h0);
    check("R2 sub addr", memAddr, 32'h1FF0);
    // byte borrow out of a 2-byte block: 0x501-3 keeps upper 0x500
    issue(32'h501, 3'd0, 32'd3, 5'd0, 1'b0, 2'd0, 1'b1, 2'b01, 32'h0000_0001);
    check("R3 borrow wrap", newBase, 32'h500);
  endtask

  task automatic t_post;
    issue(32'h100, 3'd0, 32'd9, 5'd0, 1'b0, 2'd2, 1'b0, 2'b10, 32'h0004_0001);
    check("R7 post addr", memAddr, 32'h100);
    check("R7 post newBase", newBase, 32'h104);
    check("R7 post wbEn", {31'b0, wbEn}, 32'h1);
  endtask

  task automatic t_field1;
    // field1 = 2 (8-byte block), reg 2 mode 10; halfword +3 from 0x3006
    issue(32'h3006, 3'd2, 32'd3, 5'd0, 1'b0, 2'd1, 1'b0, 2'b01, 32'h0040_0020);
    check("R4 field1 wrap", newBase, 32'h3004);
    // reg 0 under the same word is linear
    issue(32'h3006, 3'd0, 32'd3, 5'd0, 1'b0, 2'd1, 1'b0, 2'b01, 32'h0040_0020);
    check("R5 mode00 linear", newBase, 32'h300C);
  endtask

  task automatic t_reserved;
    issue(32'h100, 3'd1, 32'd9, 5'd0, 1'b0, 2'd2, 1'b0, 2'b01, 32'h0004_000C);
    check("R5 mode11 linear", newBase, 32'h124);
  endtask

  task automatic t_full;
    issue(32'hFFFF_FFF0, 3'd0, 32'h20, 5'd0, 1'b0, 2'd0, 1'b0, 2'b01, 32'h001F_0001);
    check("R9 field31", newBase, 32'h10);
  endtask

  task automatic t_imm;
    issue(32'h0, 3'd0, 32'hFFFF, 5'd5, 1'b1, 2'd3, 1'b0, 2'b00, 32'h0);
    check("R10 imm", memAddr, 32'h28);
    issue(32'h0, 3'd0, 32'h10, 5'd5, 1'b0, 2'd0, 1'b0, 2'b00, 32'h0);
    check("R10 reg", memAddr, 32'h10);
  endtask

  task automatic t_idle;
    @(negedge clk);
    check("R11 idle outValid", {31'b0, outValid}, 32'h0);
    check("R11 idle wbEn", {31'b0, wbEn}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    t_wrapExample();
    t_scale();
    t_subtract();
    t_post();
    t_field1();
    t_reserved();
    t_full();
    t_imm();
    t_idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule